// File: doc/BRIEF.md
# Barrel-Threaded Issue Scheduler

This block shares one in-order host pipeline among many hardware thread contexts. In every host cycle it offers exactly one thread, or none, for issue into the pipeline. Consecutive pipeline slots never carry the same thread. A thread's previous operation has therefore always left the pipeline before that thread issues again, so the pipeline needs no bypass or forwarding paths between adjacent slots.

A thread is eligible when three conditions hold:
- an external timing model grants it permission for this host cycle;
- it has no memory operation outstanding;
- it did not take the immediately preceding pipeline slot.

The scheduler searches round-robin, starting at the thread after the last one issued, and skips ineligible threads within the same cycle. When a memory operation issues, its thread's pending bit is set. A completion pulse carrying that thread's ID clears the bit, and the other threads keep using the pipeline in the meantime. Combinational pick logic is shared by all threads. Per-thread state is one pending bit each, indexed by thread ID.

The issue offer is a valid/ready stream. `iss_valid` and `iss_tid` are recomputed every cycle from the current state and the timing model's grants. They are a fresh offer each cycle and are not held while `iss_ready` is low. An issue is committed only in a cycle where `iss_valid` and `iss_ready` are both high. Without a handshake, the round-robin position and the pending bits are unchanged by the offer, and `iss_mem` is ignored. Completion pulses are plain inputs that are always accepted.

Top module: `barrel_sched`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every pending bit, forgets the previous slot and sets the round-robin start to thread 0. With all grants high, the first offer after reset is thread 0.
- R2: The offered thread is the first eligible thread found when scanning upward from (last committed thread + 1), wrapping from NTHR-1 to 0.
- R3: A thread committed in one cycle is never offered in the next cycle. If it is the only thread otherwise eligible, that next cycle is a bubble.
- R4: A thread whose `tm_go` bit is low in a cycle is never offered in that cycle.
- R5: Committing an issue with `iss_mem` high marks that thread pending, and a pending thread is not offered. A `cmp_valid` pulse whose `cmp_tid` names a pending thread clears its bit, and the thread is eligible from the following cycle.
- R6: A completion pulse naming a thread that is not pending changes nothing. `cmp_tid` is ignored while `cmp_valid` is low.
- R7: `iss_bubble` is high exactly when no thread is eligible, and `iss_valid` is its complement.
- R8: In a cycle with `iss_ready` low, nothing is committed. The round-robin start is unchanged, `iss_mem` is ignored, and the next cycle excludes no thread as the previous slot.
- R9: With all grants high, `iss_ready` held high, every issue a memory operation and each completion arriving 63 cycles after its issue, the scheduler offers an issue in every cycle and each thread reissues exactly NTHR cycles after its previous issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous reset, active high |
| tm_go | input | NTHR | Per-thread permission from the timing model for this cycle |
| iss_valid | output | 1 | An issue is offered this cycle |
| iss_ready | input | 1 | Pipeline accepts the offered issue |
| iss_tid | output | TIDW | Thread ID of the offered issue (0 when not valid) |
| iss_mem | input | 1 | The offered thread's operation is a memory operation; sampled only on handshake |
| iss_bubble | output | 1 | No thread is eligible; the pipeline slot is empty |
| cmp_valid | input | 1 | Memory or timing-event completion pulse |
| cmp_tid | input | TIDW | Thread ID the completion belongs to |

## Verification
A wrong pending bit shows at the ports on that thread's next turn in the rotation. A stuck-set bit makes the thread silently skipped, and a lost set lets it issue while its memory operation is outstanding. Either way the error appears within NTHR cycles when all grants are high. A wrong round-robin start or a wrong previous-slot record changes `iss_tid` in the very next cycle, so the cycle-by-cycle comparison against the behavioural model catches it one cycle after the faulty commit. Back-pressure phases with random `iss_ready` and `iss_mem` expose any state that changes without a handshake.

// File: rtl/bsched_pkg.sv
package bsched_pkg;

  // Kind of the most recent pipeline slot.
  typedef enum logic {
    SLOT_BUBBLE = 1'b0,
    SLOT_ISSUE  = 1'b1
  } slot_e;

  // Thread-ID width for a given thread count, at least one bit.
  function automatic int tid_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bsched_pend.sv
module bsched_pend #(
  parameter int NTHR = 64,
  parameter int TIDW = bsched_pkg::tid_width(NTHR)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_valid,
  input  logic [TIDW-1:0] set_tid,
  input  logic            clr_valid,
  input  logic [TIDW-1:0] clr_tid,
  output logic [NTHR-1:0] pend
);

  logic [NTHR-1:0] pend_q;

  // One pending bit per thread. A clear only acts on a set bit, so a new set
  // for a thread that was idle always survives.
  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    logic hit_set, hit_clr;
    assign hit_set = set_valid && (set_tid == TIDW'(g));
    assign hit_clr = clr_valid && (clr_tid == TIDW'(g));
    always_ff @(posedge clk) begin
      if (rst) pend_q[g] <= 1'b0;
      else     pend_q[g] <= (pend_q[g] && !hit_clr) || hit_set;
    end
  end

  assign pend = pend_q;

  // R5: a committed memory issue leaves its thread pending
  a_r5_set_marks: assert property (@(posedge clk) disable iff (rst)
    set_valid |=> pend_q[$past(set_tid)]);

  // R5: completion for a pending thread releases it
  a_r5_clear_releases: assert property (@(posedge clk) disable iff (rst)
    (clr_valid && pend_q[clr_tid] && !(set_valid && set_tid == clr_tid))
      |=> !pend_q[$past(clr_tid)]);

  // R8: no pending bit appears without a committed memory issue
  a_r8_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
    !set_valid |=> ((pend_q & ~$past(pend_q)) == '0));

  // R1: reset leaves nothing pending
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pend_q == '0));

endmodule

// File: rtl/bsched_rr_pick.sv
module bsched_rr_pick #(
  parameter int NTHR = 64,
  parameter int TIDW = bsched_pkg::tid_width(NTHR)
) (
  input  logic [NTHR-1:0] req,
  input  logic [TIDW-1:0] start,
  output logic [NTHR-1:0] gnt,
  output logic [TIDW-1:0] gnt_tid,
  output logic            any
);

  localparam logic [NTHR-1:0] ONE = {{(NTHR-1){1'b0}}, 1'b1};

  logic [NTHR-1:0] upper_mask;
  logic [NTHR-1:0] upper_req;
  logic [NTHR-1:0] pool;

  // Threads at or above the start index are searched first.
  for (genvar g = 0; g < NTHR; g++) begin : g_mask
    assign upper_mask[g] = (TIDW'(g) >= start);
  end

  assign upper_req = req & upper_mask;
  assign pool      = (|upper_req) ? upper_req : req;
  // Isolate the lowest set bit of the chosen pool.
  assign gnt       = pool & (~pool + ONE);
  assign any       = |req;

  always_comb begin
    gnt_tid = '0;
    for (int i = 0; i < NTHR; i++) begin
      if (gnt[i]) gnt_tid = gnt_tid | TIDW'(i);
    end
  end

endmodule

// File: rtl/barrel_sched.sv
module barrel_sched #(
  parameter int NTHR = 64,
  parameter int TIDW = bsched_pkg::tid_width(NTHR)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NTHR-1:0] tm_go,
  output logic            iss_valid,
  input  logic            iss_ready,
  output logic [TIDW-1:0] iss_tid,
  input  logic            iss_mem,
  output logic            iss_bubble,
  input  logic            cmp_valid,
  input  logic [TIDW-1:0] cmp_tid
);
  import bsched_pkg::*;

  localparam logic [TIDW-1:0] LAST_TID = TIDW'(NTHR - 1);

  logic [TIDW-1:0] ptr_q;
  slot_e           prev_kind_q;
  logic [TIDW-1:0] prev_tid_q;

  logic [NTHR-1:0] pend;
  logic [NTHR-1:0] prev_mask;
  logic [NTHR-1:0] elig;
  logic [NTHR-1:0] gnt;
  logic [TIDW-1:0] gnt_tid;
  logic            any_elig;
  logic            iss_fire;

  // Exclude the thread that took the previous slot.
  for (genvar g = 0; g < NTHR; g++) begin : g_prev
    assign prev_mask[g] = (prev_kind_q == SLOT_ISSUE) && (prev_tid_q == TIDW'(g));
  end

  assign elig = tm_go & ~pend & ~prev_mask;

  bsched_rr_pick #(.NTHR(NTHR), .TIDW(TIDW)) u_pick (
    .req     (elig),
    .start   (ptr_q),
    .gnt     (gnt),
    .gnt_tid (gnt_tid),
    .any     (any_elig)
  );

  assign iss_valid  = any_elig;
  assign iss_bubble = !any_elig;
  assign iss_tid    = gnt_tid;
  assign iss_fire   = iss_valid && iss_ready;

  bsched_pend #(.NTHR(NTHR), .TIDW(TIDW)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .set_valid (iss_fire && iss_mem),
    .set_tid   (gnt_tid),
    .clr_valid (cmp_valid),
    .clr_tid   (cmp_tid),
    .pend      (pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q       <= '0;
      prev_kind_q <= SLOT_BUBBLE;
      prev_tid_q  <= '0;
    end else if (iss_fire) begin
      ptr_q       <= (gnt_tid == LAST_TID) ? '0 : gnt_tid + TIDW'(1);
      prev_kind_q <= SLOT_ISSUE;
      prev_tid_q  <= gnt_tid;
    end else begin
      prev_kind_q <= SLOT_BUBBLE;
    end
  end

  // R2: at most one thread granted, and only an eligible one
  a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt) && ((gnt & ~elig) == '0));

  // R3: no thread takes two consecutive slots
  a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    iss_fire |=> !(iss_valid && iss_tid == $past(iss_tid)));

  // R4: an offered thread holds its timing-model grant
  a_r4_go_gates: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> tm_go[iss_tid]);

  // R5: a pending thread is never offered
  a_r5_pending_blocks: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> !pend[iss_tid]);

  // R7: a bubble leaves at most the previous slot's thread otherwise ready
  a_r7_bubble_only_when_idle: assert property (@(posedge clk) disable iff (rst)
    iss_bubble |-> ($countones(tm_go & ~pend) <= 1));

  // R8: without a handshake the round-robin start holds
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    !iss_ready |=> $stable(ptr_q));

  // R1: reset returns the scan start to thread 0
  a_r1_reset_ptr: assert property (@(posedge clk)
    rst |=> (ptr_q == '0));

endmodule

// File: tb/barrel_sched_tb.sv
module barrel_sched_tb;
  localparam int N = 64;
  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] tm_go = '0;
  logic         iss_valid;
  logic         iss_ready = 1'b0;
  logic [W-1:0] iss_tid;
  logic         iss_mem = 1'b0;
  logic         iss_bubble;
  logic         cmp_valid = 1'b0;
  logic [W-1:0] cmp_tid = '0;

  always #2 clk = ~clk; // 250 MHz

  barrel_sched #(.NTHR(N)) u_dut (
    .clk(clk), .rst(rst), .tm_go(tm_go), .iss_valid(iss_valid),
    .iss_ready(iss_ready), .iss_tid(iss_tid), .iss_mem(iss_mem),
    .iss_bubble(iss_bubble), .cmp_valid(cmp_valid), .cmp_tid(cmp_tid)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural reference state
  bit m_pend [N];
  int m_ptr;
  int m_last;
  bit m_lv;
  bit x_fire;
  int x_tid;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_pend[i] = 0;
    m_ptr = 0; m_last = 0; m_lv = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; iss_ready = 0; cmp_valid = 0; iss_mem = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  task automatic step(input logic [N-1:0] go, input bit rdy, input bit mem,
                      input bit cv, input int ctid, input string tag);
    bit ev; int et;
    @(negedge clk);
    tm_go = go; iss_ready = rdy; iss_mem = mem;
    cmp_valid = cv; cmp_tid = W'(ctid);
    #1;
    ev = 0; et = 0;
    for (int i = 0; i < N; i++) begin
      int t;
      t = (m_ptr + i) % N;
      if (go[t] && !m_pend[t] && !(m_lv && t == m_last)) begin
        ev = 1; et = t; break;
      end
    end
    chk({tag, " valid"}, int'(iss_valid), int'(ev));
    chk({tag, " bubble"}, int'(iss_bubble), int'(!ev));
    if (ev) chk({tag, " tid"}, int'(iss_tid), et);
    x_fire = ev && rdy;
    x_tid = et;
    if (cv && m_pend[ctid]) m_pend[ctid] = 0;
    if (x_fire) begin
      if (mem) m_pend[et] = 1;
      m_ptr = (et + 1) % N; m_last = et; m_lv = 1;
    end else begin
      m_lv = 0;
    end
  endtask

  function automatic logic [N-1:0] rnd_mask();
    return {$urandom(), $urandom()};
  endfunction

  function automatic int pick_pending();
    int s;
    s = $urandom % N;
    for (int i = 0; i < N; i++) if (m_pend[(s + i) % N]) return (s + i) % N;
    return s;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion (R1..R9 run)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int q[$];
    do_reset();
    // R1: first offer after reset is thread 0
    step('1, 1, 0, 0, 0, "R1");
    chk("R1 first tid", int'(iss_tid), 0);

    // R2: plain rotation with every grant high
    repeat (100) step('1, 1, 0, 0, 0, "R2");

    // R4: random and sparse grant masks
    repeat (80) step(rnd_mask(), 1, 0, 0, 0, "R4");
    repeat (80) step(rnd_mask() & rnd_mask() & rnd_mask(), 1, 0, 0, 0, "R4");

    // R3: a single granted thread alternates issue and bubble
    repeat (12) step(N'(1) << 5, 1, 0, 0, 0, "R3");
    // R7: no grants at all
    repeat (6) step('0, 1, 0, 0, 0, "R7");
    repeat (12) step((N'(1) << 5) | (N'(1) << 9), 1, 0, 0, 0, "R7");

    // R5 / R6: memory issues, completions for pending and idle threads
    repeat (400) begin
      bit cv; int ct;
      cv = ($urandom % 2) == 0;
      ct = (($urandom % 3) == 0) ? int'($urandom % N) : pick_pending();
      step(rnd_mask() | rnd_mask(), 1, ($urandom % 3) == 0, cv, ct,
           (cv && !m_pend[ct]) ? "R6" : "R5");
    end
    // R6: cmp_tid toggles while cmp_valid is low
    repeat (40) step('1, 1, 0, 0, int'($urandom % N), "R6");

    // R8: random back-pressure with memory flags offered
    repeat (300) step(rnd_mask() | rnd_mask(), ($urandom % 2) == 0,
                      ($urandom % 2) == 0, ($urandom % 4) == 0, pick_pending(), "R8");

    // R9: full rotation, every issue memory, completion 63 cycles later
    do_reset();
    repeat (300) begin
      bit cv; int ct;
      cv = 0; ct = 0;
      if (q.size() == 63) begin
        ct = q.pop_front();
        cv = (ct >= 0);
        if (ct < 0) ct = 0;
      end
      step('1, 1, 1, cv, ct, "R9");
      chk("R9 no bubble", int'(iss_valid), 1);
      q.push_back(x_fire ? x_tid : -1);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule